// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the transmit-side DMA front end of a network controller. Software builds a linked list of four-word descriptors in memory and loads the list base address. It then sets the transmit enable and issues a poll demand. The engine reads the descriptor at its current pointer and tests the ownership flag. If hardware owns the descriptor, the engine fetches the referenced buffer a word at a time and streams it out as bytes, marking the start and end of each frame. It then writes the status word back with ownership cleared and moves to the descriptor named by the link word.

A frame may span several descriptors. A first-segment flag and a last-segment flag bracket the frame, and each link word points at the next piece. The engine keeps walking the list as long as it finds descriptors it owns and transmit stays enabled. When it reaches a descriptor still owned by software, it parks on that descriptor and waits for the next poll demand. The MAC, CRC generation, collision handling and cache coherency are outside this block. The status word it writes back carries only its own error flag.

Top module: `txd_ring_engine`

## Requirements
- R1: While reset is asserted and after its release, `tx_valid`, `mem_req`, `frame_done` and `tx_irq` are low until a poll demand is accepted.
- R2: A descriptor occupies four consecutive 32-bit words at the pointer, at byte offsets +0 (status), +4 (control), +8 (buffer address) and +12 (link). The engine reads them in that order.
- R3: When word0 bit 31 (ownership) reads 0, the engine reads no further words of that descriptor and goes idle without moving its pointer. The next poll demand fetches the same address again.
- R4: A CSR write to address 0 sets the enable from bit 4. A poll demand (bit 5) is accepted only when the same write also sets bit 4. A poll demand written with bit 4 clear causes no memory access and no output. A CSR write to address 1 loads the pointer from bits 31:4.
- R5: The segment's bytes go out in little-endian lane order: the byte at address A is bits 8*(A mod 4)+7..8*(A mod 4) of the word at A rounded down to a multiple of 4. Output starts at the buffer address, at any byte alignment, and the byte count is word1 bits 14:0.
- R6: `tx_sof` is high only with the first byte of a segment whose word1 bit 22 is set. `tx_eof` is high only with the last byte of a segment whose word1 bit 21 is set.
- R7: `tx_nocrc` equals word1 bit 16 of the current segment on every byte of that segment.
- R8: After a segment's bytes are sent, the engine writes word0 with bit 31 clear. The value written is 0x00000000 for a segment that was sent.
- R9: A descriptor with length 0 emits no bytes, and its word0 is written as 0x00008000 (bit 15, error).
- R10: After the word0 writeback, the pointer takes word3 bits 31:4. While enable stays set, the engine fetches that descriptor at once, so one poll demand walks the whole owned chain.
- R11: `frame_done` pulses for exactly one cycle after the writeback of a descriptor with word1 bit 21 set. `tx_irq` pulses with it only when word1 bit 23 is also set.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sof`, `tx_eof` and `tx_nocrc` hold their values.
- R13: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high. A transfer completes in a cycle where both are high.
- R14: A poll demand written in the same cycle the engine consumes an earlier one is kept, and it triggers another word0 fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 1 | CSR select: 0 control, 1 list pointer |
| csr_wdata | input | 32 | CSR write data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory transfer complete |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_data | output | 8 | Byte value |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_nocrc | output | 1 | Segment asks for no CRC append |
| frame_done | output | 1 | One-cycle pulse after a frame's last writeback |
| tx_irq | output | 1 | Completion interrupt pulse for the frame |

## Verification
Two events can land in the same cycle: software writing a poll demand, and the engine consuming the previous demand as it leaves idle. The bench provokes the overlap by sweeping the gap between two demands over eight offsets. Before the second demand it hands a descriptor to hardware that the first demand's fetch may already have seen as software-owned. In every offset the frame must go out exactly once, with exactly one done pulse. Backpressure from a toggling `tx_ready` also meets word fetches across unaligned buffer boundaries. There the byte order and the frame markers are compared byte by byte.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int DESC_SHIFT = 4;   // descriptors are 16-byte aligned
  localparam int LEN_W      = 15;

  // descriptor word0
  localparam int OWN_BIT    = 31;
  localparam int ERR_BIT    = 15;
  // descriptor word1
  localparam int IRQ_BIT    = 23;
  localparam int FIRST_BIT  = 22;
  localparam int LAST_BIT   = 21;
  localparam int NOCRC_BIT  = 16;

  // control register
  localparam int CTL_ON_BIT   = 4;
  localparam int CTL_KICK_BIT = 5;
  localparam logic CSR_CTL    = 1'b0;
  localparam logic CSR_PTR    = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_RD2,
    ST_RD3,
    ST_STREAM,
    ST_WB
  } walk_st_t;

  typedef struct packed {
    logic             irq;
    logic             first;
    logic             last;
    logic             nocrc;
    logic [LEN_W-1:0] len;
  } seg_ctl_t;

endpackage

// File: rtl/txd_csr.sv
module txd_csr
  import txd_pkg::*;
#(
  parameter int AW = 32,
  localparam int PW = AW - DESC_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic          csr_addr,
  input  logic [31:0]   csr_wdata,
  input  logic          kick_take,
  output logic          tx_on,
  output logic          kick_pend,
  output logic          base_wr,
  output logic [PW-1:0] base_val
);

  logic ctl_wr;
  logic on_q, on_d;
  logic kick_q, kick_d;
  logic unused_lo;

  assign ctl_wr    = csr_we && (csr_addr == CSR_CTL);
  assign base_wr   = csr_we && (csr_addr == CSR_PTR);
  assign base_val  = csr_wdata[AW-1:DESC_SHIFT];
  assign unused_lo = ^csr_wdata[DESC_SHIFT-1:0];

  always_comb begin
    on_d   = on_q;
    kick_d = kick_q;
    if (ctl_wr) on_d = csr_wdata[CTL_ON_BIT];
    // consumption first, a fresh demand in the same cycle wins
    if (kick_take) kick_d = 1'b0;
    if (ctl_wr && !csr_wdata[CTL_ON_BIT]) kick_d = 1'b0;
    if (ctl_wr && csr_wdata[CTL_ON_BIT] && csr_wdata[CTL_KICK_BIT]) kick_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      if (ctl_wr) on_q <= on_d;
      kick_q <= kick_d;
    end
  end

  assign tx_on     = on_q;
  assign kick_pend = kick_q;

endmodule

// File: rtl/txd_serializer.sv
module txd_serializer
  import txd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seg_load,
  input  seg_ctl_t    seg_ctl,
  input  logic [1:0]  seg_lane,
  input  logic        word_load,
  input  logic [31:0] word_data,
  input  logic        tx_ready,
  output logic        word_need,
  output logic        seg_fin,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_sof,
  output logic        tx_eof,
  output logic        tx_nocrc
);

  localparam int LANES = 4;

  logic             act_q, act_d;
  logic             held_q, held_d;
  logic [31:0]      word_q;
  logic [1:0]       lane_q, lane_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             sofp_q, sofp_d;
  seg_ctl_t         ctl_q;
  logic             accept;
  logic             last_byte;
  logic [7:0]       lane_byte [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = word_q[8*g +: 8];
  end

  assign tx_valid  = act_q && held_q;
  assign tx_data   = lane_byte[lane_q];
  assign last_byte = (rem_q == LEN_W'(1));
  assign tx_sof    = tx_valid && sofp_q;
  assign tx_eof    = tx_valid && ctl_q.last && last_byte;
  assign tx_nocrc  = tx_valid && ctl_q.nocrc;
  assign accept    = tx_valid && tx_ready;
  assign seg_fin   = accept && last_byte;
  assign word_need = act_q && !held_q;

  always_comb begin
    act_d  = act_q;
    held_d = held_q;
    lane_d = lane_q;
    rem_d  = rem_q;
    sofp_d = sofp_q;
    if (seg_load) begin
      act_d  = 1'b1;
      held_d = 1'b0;
      lane_d = seg_lane;
      rem_d  = seg_ctl.len;
      sofp_d = seg_ctl.first;
    end else if (word_load) begin
      held_d = 1'b1;
    end else if (accept) begin
      rem_d  = rem_q - LEN_W'(1);
      lane_d = lane_q + 2'd1;
      sofp_d = 1'b0;
      if (last_byte) begin
        act_d  = 1'b0;
        held_d = 1'b0;
      end else if (lane_q == 2'd3) begin
        held_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      held_q <= 1'b0;
      lane_q <= '0;
      rem_q  <= '0;
      sofp_q <= 1'b0;
      ctl_q  <= '0;
      word_q <= '0;
    end else begin
      act_q  <= act_d;
      held_q <= held_d;
      lane_q <= lane_d;
      rem_q  <= rem_d;
      sofp_q <= sofp_d;
      if (seg_load)  ctl_q  <= seg_ctl;
      if (word_load) word_q <= word_data;
    end
  end

endmodule

// File: rtl/txd_walker.sv
module txd_walker
  import txd_pkg::*;
#(
  parameter int AW = 32,
  localparam int PW = AW - DESC_SHIFT,
  localparam int WW = AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_on,
  input  logic          kick_pend,
  output logic          kick_take,
  input  logic          base_wr,
  input  logic [PW-1:0] base_val,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          seg_load,
  output seg_ctl_t      seg_ctl,
  output logic [1:0]    seg_lane,
  input  logic          word_need,
  output logic          word_load,
  input  logic          seg_fin,
  output logic          frame_done,
  output logic          tx_irq
);

  walk_st_t       st_q, st_d;
  logic [PW-1:0]  ptr_q, ptr_d;
  logic [PW-1:0]  link_q, link_d;
  logic [AW-1:0]  baddr_q, baddr_d;
  logic [WW-1:0]  waddr_q, waddr_d;
  seg_ctl_t       ctl_q, ctl_d;
  logic           err_q, err_d;
  logic           done_q, done_d;
  logic           irq_q, irq_d;
  logic           xfer;
  logic [1:0]     woff;

  // memory request decode
  always_comb begin
    mem_req = 1'b0;
    mem_we  = 1'b0;
    woff    = 2'd0;
    unique case (st_q)
      ST_RD0:    begin mem_req = 1'b1; woff = 2'd0; end
      ST_RD1:    begin mem_req = 1'b1; woff = 2'd1; end
      ST_RD2:    begin mem_req = 1'b1; woff = 2'd2; end
      ST_RD3:    begin mem_req = 1'b1; woff = 2'd3; end
      ST_WB:     begin mem_req = 1'b1; mem_we = 1'b1; end
      ST_STREAM: mem_req = word_need;
      default:   ;
    endcase
  end

  assign mem_addr = (st_q == ST_STREAM) ? {waddr_q, 2'b00} : {ptr_q, woff, 2'b00};

  always_comb begin
    mem_wdata          = '0;
    mem_wdata[ERR_BIT] = err_q;
  end

  assign xfer      = mem_req && mem_ack;
  assign kick_take = (st_q == ST_IDLE) && tx_on && kick_pend;
  assign word_load = (st_q == ST_STREAM) && xfer;
  assign seg_ctl   = ctl_q;
  assign seg_lane  = baddr_q[1:0];

  // next state
  always_comb begin
    st_d     = st_q;
    ptr_d    = ptr_q;
    link_d   = link_q;
    baddr_d  = baddr_q;
    waddr_d  = waddr_q;
    ctl_d    = ctl_q;
    err_d    = err_q;
    done_d   = 1'b0;
    irq_d    = 1'b0;
    seg_load = 1'b0;
    unique case (st_q)
      ST_IDLE: if (kick_take) st_d = ST_RD0;
      ST_RD0: if (xfer) st_d = mem_rdata[OWN_BIT] ? ST_RD1 : ST_IDLE;
      ST_RD1: if (xfer) begin
        ctl_d.irq   = mem_rdata[IRQ_BIT];
        ctl_d.first = mem_rdata[FIRST_BIT];
        ctl_d.last  = mem_rdata[LAST_BIT];
        ctl_d.nocrc = mem_rdata[NOCRC_BIT];
        ctl_d.len   = mem_rdata[LEN_W-1:0];
        st_d        = ST_RD2;
      end
      ST_RD2: if (xfer) begin
        baddr_d = mem_rdata[AW-1:0];
        st_d    = ST_RD3;
      end
      ST_RD3: if (xfer) begin
        link_d = mem_rdata[AW-1:DESC_SHIFT];
        if (ctl_q.len == '0) begin
          err_d = 1'b1;
          st_d  = ST_WB;
        end else begin
          err_d    = 1'b0;
          seg_load = 1'b1;
          waddr_d  = baddr_q[AW-1:2];
          st_d     = ST_STREAM;
        end
      end
      ST_STREAM: begin
        if (xfer) waddr_d = waddr_q + WW'(1);
        if (seg_fin) st_d = ST_WB;
      end
      ST_WB: if (xfer) begin
        ptr_d  = link_q;
        done_d = ctl_q.last;
        irq_d  = ctl_q.last && ctl_q.irq;
        st_d   = tx_on ? ST_RD0 : ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (base_wr) ptr_d = base_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      link_q  <= '0;
      baddr_q <= '0;
      waddr_q <= '0;
      ctl_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      link_q  <= link_d;
      baddr_q <= baddr_d;
      waddr_q <= waddr_d;
      ctl_q   <= ctl_d;
      err_q   <= err_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
    end
  end

  assign frame_done = done_q;
  assign tx_irq     = irq_q;

endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
  import txd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic          csr_addr,
  input  logic [31:0]   csr_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_sof,
  output logic          tx_eof,
  output logic          tx_nocrc,
  output logic          frame_done,
  output logic          tx_irq
);

  localparam int PW = AW - DESC_SHIFT;

  logic [1:0]    rst_sync_q;
  logic          core_rst_n;
  logic          tx_on, kick_pend, kick_take;
  logic          base_wr;
  logic [PW-1:0] base_val;
  logic          seg_load, word_load, word_need, seg_fin;
  seg_ctl_t      seg_ctl;
  logic [1:0]    seg_lane;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  txd_csr #(.AW(AW)) u_csr (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .kick_take (kick_take),
    .tx_on     (tx_on),
    .kick_pend (kick_pend),
    .base_wr   (base_wr),
    .base_val  (base_val)
  );

  txd_walker #(.AW(AW)) u_walk (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .tx_on      (tx_on),
    .kick_pend  (kick_pend),
    .kick_take  (kick_take),
    .base_wr    (base_wr),
    .base_val   (base_val),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .seg_load   (seg_load),
    .seg_ctl    (seg_ctl),
    .seg_lane   (seg_lane),
    .word_need  (word_need),
    .word_load  (word_load),
    .seg_fin    (seg_fin),
    .frame_done (frame_done),
    .tx_irq     (tx_irq)
  );

  txd_serializer u_ser (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .seg_load  (seg_load),
    .seg_ctl   (seg_ctl),
    .seg_lane  (seg_lane),
    .word_load (word_load),
    .word_data (mem_rdata),
    .tx_ready  (tx_ready),
    .word_need (word_need),
    .seg_fin   (seg_fin),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_sof    (tx_sof),
    .tx_eof    (tx_eof),
    .tx_nocrc  (tx_nocrc)
  );

endmodule

// File: rtl/txd_ring_engine_chk.sv
module txd_ring_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_sof,
  input logic          tx_eof,
  input logic          tx_nocrc,
  input logic          frame_done,
  input logic          tx_irq
);

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sof)
                                 && $stable(tx_eof) && $stable(tx_nocrc)));

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R8
  wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[31]);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R11
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> frame_done);

  // R6
  marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof || tx_eof || tx_nocrc) |-> tx_valid);

endmodule

bind txd_ring_engine txd_ring_engine_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_sof     (tx_sof),
  .tx_eof     (tx_eof),
  .tx_nocrc   (tx_nocrc),
  .frame_done (frame_done),
  .tx_irq     (tx_irq)
);

// File: tb/txd_ring_engine_test.sv
`timescale 1ns/1ps
module txd_ring_engine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_we;
  logic        csr_addr;
  logic [31:0] csr_wdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_sof, tx_eof, tx_nocrc;
  logic [7:0]  tx_data;
  logic        frame_done, tx_irq;

  always #10 clk = ~clk;   // 50 MHz

  txd_ring_engine uut (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_nocrc(tx_nocrc),
    .frame_done(frame_done), .tx_irq(tx_irq)
  );

  int nchk = 0;
  int nfail = 0;

  logic [31:0] mem [0:63];
  int          hold_err = 0;
  int          watch_addr = -1;
  int          watch_hits = 0;

  logic [7:0]  cap_b   [0:127];
  logic        cap_sof [0:127];
  logic        cap_eof [0:127];
  logic        cap_nc  [0:127];
  int          ncap = 0;
  int          n_done = 0;
  int          n_irq = 0;
  logic        ready_slow = 1'b0;
  int          cyc = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] mk_ctl(input logic irq, input logic first,
                                         input logic last, input logic nocrc,
                                         input int len);
    return (32'(irq) << 23) | (32'(first) << 22) | (32'(last) << 21) |
           (32'(nocrc) << 16) | 32'(len & 32'h7fff);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // memory model: variable latency, acts a quarter period after the rising edge
  initial begin
    int lat = 0;
    int wcnt = 0;
    logic [31:0] seen;
    mem_ack = 1'b0;
    mem_rdata = '0;
    seen = '0;
    forever begin
      @(posedge clk); #5;
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (rst_n && mem_req) begin
        if (wcnt == 0) seen = mem_addr;
        else if (mem_addr !== seen) hold_err++;
        if (wcnt < lat) begin
          wcnt++;
        end else begin
          if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
          else begin
            mem_rdata = mem[mem_addr[7:2]];
            if (int'(mem_addr) == watch_addr) watch_hits++;
          end
          mem_ack = 1'b1;
          wcnt = 0;
          lat = (lat + 1) % 3;
        end
      end
    end
  end

  // byte sink and pulse monitor
  initial begin
    tx_ready = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      tx_ready = ready_slow ? cyc[0] : 1'b1;
      if (frame_done) n_done++;
      if (tx_irq) n_irq++;
      if (tx_valid && tx_ready) begin
        if (ncap < 128) begin
          cap_b[ncap]   = tx_data;
          cap_sof[ncap] = tx_sof;
          cap_eof[ncap] = tx_eof;
          cap_nc[ncap]  = tx_nocrc;
        end
        ncap++;
      end
    end
  end

  task automatic clear_cap();
    ncap = 0;
    n_done = 0;
    n_irq = 0;
  endtask

  task automatic csr_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic put_desc(input int a, input logic own, input logic [31:0] ctl,
                          input int buf_a, input int link);
    mem[a/4]     = own ? 32'h8000_0000 : 32'h0;
    mem[a/4 + 1] = ctl;
    mem[a/4 + 2] = 32'(buf_a);
    mem[a/4 + 3] = 32'(link);
  endtask

  task automatic settle();
    int quiet = 0;
    int guard = 0;
    while (quiet < 20 && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (!mem_req && !tx_valid) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic chk_bytes(input string r, input int base_idx, input int a, input int n);
    for (int i = 0; i < n; i++) chk(r, 32'(cap_b[base_idx + i]), 32'(pat(a + i)));
  endtask

  function automatic int count_flags(input int which);
    int c = 0;
    for (int i = 0; i < ncap && i < 128; i++) begin
      if (which == 0 && cap_sof[i]) c++;
      if (which == 1 && cap_eof[i]) c++;
      if (which == 2 && cap_nc[i])  c++;
    end
    return c;
  endfunction

  task automatic t_reset();
    chk("R1 tx_valid after reset", 32'(tx_valid), 0);
    chk("R1 mem_req after reset", 32'(mem_req), 0);
    chk("R1 frame_done after reset", 32'(frame_done), 0);
    chk("R1 tx_irq after reset", 32'(tx_irq), 0);
  endtask

  task automatic t_disabled();
    put_desc(32'h00, 1'b1, mk_ctl(1, 1, 1, 0, 6), 32'h80, 32'h10);
    put_desc(32'h10, 1'b0, mk_ctl(0, 1, 1, 0, 3), 32'h90, 32'h20);
    csr_write(1'b1, 32'h0000_0000);
    clear_cap();
    csr_write(1'b0, 32'h20);   // demand without enable
    settle();
    chk("R4 no bytes while disabled", 32'(ncap), 0);
    chk("R4 descriptor untouched while disabled", mem[0], 32'h8000_0000);
  endtask

  task automatic t_single();
    clear_cap();
    watch_addr = 32'h14;
    watch_hits = 0;
    csr_write(1'b0, 32'h30);
    settle();
    chk("R5 single length", 32'(ncap), 6);
    chk_bytes("R5 R2 single bytes", 0, 32'h80, 6);
    chk("R6 single sof first", 32'(cap_sof[0]), 1);
    chk("R6 single sof count", 32'(count_flags(0)), 1);
    chk("R6 single eof last", 32'(cap_eof[5]), 1);
    chk("R6 single eof count", 32'(count_flags(1)), 1);
    chk("R7 nocrc clear", 32'(count_flags(2)), 0);
    chk("R8 writeback word0", mem[0], 32'h0);
    chk("R11 done count", 32'(n_done), 1);
    chk("R11 irq count", 32'(n_irq), 1);
  endtask

  task automatic t_not_owned();
    chk("R3 no word1 read of unowned", 32'(watch_hits), 0);
    chk("R3 unowned word0 kept", mem[4], 32'h0);
    put_desc(32'h10, 1'b1, mk_ctl(0, 1, 1, 0, 3), 32'h90, 32'h20);
    put_desc(32'h20, 1'b0, 32'h0, 32'h0, 32'h0);
    clear_cap();
    csr_write(1'b0, 32'h30);
    settle();
    chk("R3 refetch same pointer", 32'(ncap), 3);
    chk_bytes("R3 refetch bytes", 0, 32'h90, 3);
    chk("R8 writeback second", mem[4], 32'h0);
    chk("R11 done without irq", 32'(n_done), 1);
    chk("R11 irq absent", 32'(n_irq), 0);
  endtask

  task automatic t_chain();
    // pointer now rests at 0x20
    put_desc(32'h20, 1'b1, mk_ctl(0, 1, 0, 1, 5), 32'hA1, 32'h30);
    put_desc(32'h30, 1'b1, mk_ctl(0, 0, 1, 1, 4), 32'hB3, 32'h00);
    clear_cap();
    ready_slow = 1'b1;
    csr_write(1'b0, 32'h30);
    settle();
    ready_slow = 1'b0;
    chk("R10 chain total bytes", 32'(ncap), 9);
    chk_bytes("R5 R12 seg one unaligned", 0, 32'hA1, 5);
    chk_bytes("R5 R12 seg two unaligned", 5, 32'hB3, 4);
    chk("R6 chain sof only first", 32'(cap_sof[0]), 1);
    chk("R6 chain sof count", 32'(count_flags(0)), 1);
    chk("R6 chain eof only last", 32'(cap_eof[8]), 1);
    chk("R6 chain eof count", 32'(count_flags(1)), 1);
    chk("R7 nocrc on all bytes", 32'(count_flags(2)), 9);
    chk("R10 chain single done", 32'(n_done), 1);
    chk("R8 chain writeback one", mem[8], 32'h0);
    chk("R8 chain writeback two", mem[12], 32'h0);
  endtask

  task automatic t_zero();
    // pointer now rests at 0x00 (link of previous tail)
    put_desc(32'h00, 1'b1, mk_ctl(0, 1, 1, 0, 0), 32'h80, 32'h10);
    clear_cap();
    watch_addr = 32'h10;
    watch_hits = 0;
    csr_write(1'b0, 32'h30);
    settle();
    chk("R9 zero length no bytes", 32'(ncap), 0);
    chk("R9 zero length error status", mem[0], 32'h0000_8000);
    chk("R10 link followed after zero", 32'(watch_hits != 0), 1);
    chk("R11 zero length last done", 32'(n_done), 1);
  endtask

  task automatic t_collide();
    for (int d = 0; d < 8; d++) begin
      put_desc(32'h20, 1'b0, mk_ctl(0, 1, 1, 0, 2), 32'hC0, 32'h30);
      put_desc(32'h30, 1'b0, 32'h0, 32'h0, 32'h0);
      csr_write(1'b1, 32'h20);
      clear_cap();
      csr_write(1'b0, 32'h30);
      repeat (d) @(negedge clk);
      mem[8] = 32'h8000_0000;
      csr_write(1'b0, 32'h30);
      settle();
      chk("R14 frame sent once", 32'(ncap), 2);
      chk("R14 single done", 32'(n_done), 1);
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    for (int w = 0; w < 64; w++)
      mem[w] = {pat(4*w + 3), pat(4*w + 2), pat(4*w + 1), pat(4*w)};
    rst_n = 1'b0;
    csr_we = 1'b0;
    csr_addr = 1'b0;
    csr_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_disabled();
    t_single();
    t_not_owned();
    t_chain();
    t_zero();
    t_collide();
    chk("R13 request held until ack", 32'(hold_err), 0);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule